// File: doc/BRIEF.md
# Multiblock Transfer Block-Break Controller

This block sequences a multiblock data transfer on a memory-card host controller. Software starts a transfer with a programmed number of blocks. Each time the data path reports that a block has finished, the controller stops the card transfer clock and waits for software. Software then either lets the transfer go on to the next block or ends it, in which case the controller asks the command path to send the stop command. When the last programmed block finishes, the controller goes straight to the stop command without pausing for software.

Beside the sequencer sits a FIFO-full interrupt. A read strobe can clear it only once a minimum number of transfer-clock cycles has gone by since it was raised. An earlier clear attempt is dropped. One system clock cycle stands for one transfer-clock cycle. The data shifter, the CRC logic and the stop-command serializer are outside this block.

Top module: `blkbrk_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `xclk_en`, `stop_req`, `brk_stat` and `fifo_irq` are all 0.
- R2: A `start` pulse sampled while idle sets `xclk_en` to 1 from the next cycle, and it stays 1 while a block is in flight.
- R3: A `blk_done` pulse for a block that is not the last one stops the clock in the next cycle: `xclk_en`=0 and `brk_stat`=1.
- R4: During a break, setting only `cont_bit` or only `den_bit` (with `abort_bit`=0) leaves `xclk_en`=0 and `brk_stat`=1.
- R5: During a break, `cont_bit`=1 and `den_bit`=1 together with `abort_bit`=0 resume the clock in the next cycle (`xclk_en`=1, `brk_stat`=0, `stop_req`=0), and the next block then runs.
- R6: During a break, `abort_bit`=1 gives `stop_req`=1 with `xclk_en`=1 for exactly one cycle, after which all outputs return to 0. Abort wins over a continue decision set in the same cycle.
- R7: The `blk_done` pulse that completes block number `blk_total` (a value of 0 counts as 1) goes straight to the one-cycle stop request of R6, with no break.
- R8: A rising edge on `fifo_full` sets `fifo_irq` in the next cycle.
- R9: A `fifo_rd` strobe sampled fewer than MIN_CLR (default 5) cycles after the edge that raised `fifo_irq` is ignored, and `fifo_irq` stays 1.
- R10: A `fifo_rd` strobe sampled MIN_CLR or more cycles after that edge clears `fifo_irq` in the next cycle. While `fifo_full` stays high, it is not raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one cycle counts as one transfer-clock cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a multiblock transfer |
| blk_total | input | CNT_W | Number of blocks programmed for the transfer |
| blk_done | input | 1 | Pulse from the data path when a block completes |
| cont_bit | input | 1 | Software continue-read bit |
| den_bit | input | 1 | Software data-enable bit |
| abort_bit | input | 1 | Software command-abort bit |
| fifo_full | input | 1 | FIFO full indication |
| fifo_rd | input | 1 | FIFO read strobe that attempts to clear the interrupt |
| xclk_en | output | 1 | Transfer-clock enable |
| stop_req | output | 1 | One-cycle request to send the stop command |
| brk_stat | output | 1 | High while paused at a block boundary |
| fifo_irq | output | 1 | FIFO-full interrupt |

## Verification
The bench builds the block with its default parameters: a 4-bit block count and a five-cycle clear window. This keeps every block total from 1 to 4 within reach, combined with an abort at every possible break position and with no abort at all. At each break, the bench applies the two partial continue settings before the deciding one. It also sweeps the clear-attempt offset from 1 to 8 cycles, which places the window edge between the fourth and fifth offsets.

// File: rtl/blkbrk_pkg.sv
package blkbrk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_XFER  = 3'd1,
        ST_BRK   = 3'd2,
        ST_CONT  = 3'd3,
        ST_STOP  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic xclk_en;
        logic stop_req;
        logic brk_stat;
    } seq_out_t;

    localparam int DEF_CNT_W   = 4;
    localparam int DEF_MIN_CLR = 5;

    function automatic seq_out_t decode_state(seq_state_e st);
        seq_out_t o;
        o = '0;
        case (st)
            ST_XFER: o.xclk_en = 1'b1;
            ST_CONT: o.xclk_en = 1'b1;
            ST_BRK:  o.brk_stat = 1'b1;
            ST_STOP: begin
                o.xclk_en  = 1'b1;
                o.stop_req = 1'b1;
            end
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/blkbrk_seq.sv
module blkbrk_seq
    import blkbrk_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] blk_total,
    input  logic             blk_done,
    input  logic             cont_bit,
    input  logic             den_bit,
    input  logic             abort_bit,
    output seq_out_t         outs
);
    localparam int WIDE_W = CNT_W + 1;

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] done_q, done_d;
    logic [WIDE_W-1:0] done_next_w;
    logic             last_blk;
    logic             go_on;

    assign done_next_w = {1'b0, done_q} + WIDE_W'(1);
    assign last_blk    = done_next_w >= {1'b0, blk_total};
    assign go_on       = cont_bit & den_bit;

    always_comb begin
        state_d = state_q;
        done_d  = done_q;
        case (state_q)
            ST_IDLE: begin
                done_d = '0;
                if (start) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (blk_done) begin
                    done_d  = done_next_w[CNT_W-1:0];
                    state_d = last_blk ? ST_STOP : ST_BRK;
                end
            end
            ST_BRK: begin
                if (abort_bit)  state_d = ST_STOP;
                else if (go_on) state_d = ST_CONT;
            end
            ST_CONT: state_d = ST_XFER;
            ST_STOP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign outs = decode_state(state_q);

    // R3: clock stays off while paused
    p_break_clk_off_r3: assert property (@(posedge clk) disable iff (rst)
        outs.brk_stat |-> !outs.xclk_en);
    // R4: a partial decision keeps the pause
    p_partial_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRK && !abort_bit && !(cont_bit && den_bit)) |=> outs.brk_stat);
    // R6: abort wins over continue
    p_abort_prio_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRK && abort_bit) |=> outs.stop_req);
    // R6: stop request lasts a single cycle
    p_stop_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        outs.stop_req |=> !outs.stop_req && !outs.xclk_en);
    // R5: full decision resumes the clock
    p_resume_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRK && !abort_bit && cont_bit && den_bit) |=> outs.xclk_en && !outs.brk_stat);
endmodule

// File: rtl/blkbrk_irq.sv
module blkbrk_irq
    import blkbrk_pkg::*;
#(
    parameter int MIN_CLR = DEF_MIN_CLR
) (
    input  logic clk,
    input  logic rst,
    input  logic fifo_full,
    input  logic fifo_rd,
    output logic irq
);
    localparam int AGE_W = $clog2(MIN_CLR + 1);
    localparam logic [AGE_W-1:0] AGE_OK = AGE_W'(MIN_CLR - 1);

    logic             full_q;
    logic [AGE_W-1:0] age_q;
    logic             irq_q;
    logic             clr_ok;
    logic             rise;

    assign clr_ok = age_q >= AGE_OK;
    assign rise   = fifo_full & ~full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            irq_q  <= 1'b0;
            age_q  <= '0;
        end else begin
            full_q <= fifo_full;
            if (!irq_q) begin
                if (rise) begin
                    irq_q <= 1'b1;
                    age_q <= '0;
                end
            end else if (fifo_rd && clr_ok) begin
                irq_q <= 1'b0;
            end else if (!clr_ok) begin
                age_q <= age_q + AGE_W'(1);
            end
        end
    end

    assign irq = irq_q;

    // R9: early clear attempts are dropped
    p_early_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr_ok) |=> irq_q);
    // R10: a late read clears the interrupt
    p_late_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_q && fifo_rd && clr_ok) |=> !irq_q);
    // R8: rising full edge raises the interrupt
    p_raise_r8: assert property (@(posedge clk) disable iff (rst)
        (!irq_q && rise) |=> irq_q);
endmodule

// File: rtl/blkbrk_ctrl.sv
module blkbrk_ctrl
    import blkbrk_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int MIN_CLR = DEF_MIN_CLR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] blk_total,
    input  logic             blk_done,
    input  logic             cont_bit,
    input  logic             den_bit,
    input  logic             abort_bit,
    input  logic             fifo_full,
    input  logic             fifo_rd,
    output logic             xclk_en,
    output logic             stop_req,
    output logic             brk_stat,
    output logic             fifo_irq
);
    seq_out_t seq_o;

    blkbrk_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .blk_total (blk_total),
        .blk_done  (blk_done),
        .cont_bit  (cont_bit),
        .den_bit   (den_bit),
        .abort_bit (abort_bit),
        .outs      (seq_o)
    );

    blkbrk_irq #(.MIN_CLR(MIN_CLR)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .fifo_full (fifo_full),
        .fifo_rd   (fifo_rd),
        .irq       (fifo_irq)
    );

    assign xclk_en  = seq_o.xclk_en;
    assign stop_req = seq_o.stop_req;
    assign brk_stat = seq_o.brk_stat;
endmodule

// File: tb/sim_blkbrk_ctrl.sv
module sim_blkbrk_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 0, blk_done = 0, cont_bit = 0, den_bit = 0, abort_bit = 0;
    logic       fifo_full = 0, fifo_rd = 0;
    logic [3:0] blk_total = 4'd1;
    logic       xclk_en, stop_req, brk_stat, fifo_irq;
    int         total = 0, bad = 0, cyc = 0;

    always #4 clk = ~clk;

    blkbrk_ctrl u0 (
        .clk(clk), .rst(rst), .start(start), .blk_total(blk_total),
        .blk_done(blk_done), .cont_bit(cont_bit), .den_bit(den_bit),
        .abort_bit(abort_bit), .fifo_full(fifo_full), .fifo_rd(fifo_rd),
        .xclk_en(xclk_en), .stop_req(stop_req), .brk_stat(brk_stat),
        .fifo_irq(fifo_irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // outputs packed as {xclk_en, stop_req, brk_stat, fifo_irq}
    function automatic logic [3:0] outs();
        return {xclk_en, stop_req, brk_stat, fifo_irq};
    endfunction

    task automatic run_xfer(input int nblk, input int abort_at);
        blk_total = 4'(nblk);
        start = 1; tick(); start = 0;
        check("R2 start", outs(), 4'b1000);
        for (int b = 1; b <= nblk; b++) begin
            tick();
            check("R2 in flight", outs(), 4'b1000);
            blk_done = 1; tick(); blk_done = 0;
            if (b == nblk) begin
                check("R7 last block stop", outs(), 4'b1100);
                tick();
                check("R6 stop one cycle", outs(), 4'b0000);
                return;
            end
            check("R3 break", outs(), 4'b0010);
            cont_bit = 1; tick();
            check("R4 cont only", outs(), 4'b0010);
            cont_bit = 0; den_bit = 1; tick();
            check("R4 den only", outs(), 4'b0010);
            cont_bit = 1;
            if (b == abort_at) begin
                abort_bit = 1; tick();
                abort_bit = 0; cont_bit = 0; den_bit = 0;
                check("R6 abort priority", outs(), 4'b1100);
                tick();
                check("R6 stop one cycle", outs(), 4'b0000);
                return;
            end
            tick();
            cont_bit = 0; den_bit = 0;
            check("R5 resume", outs(), 4'b1000);
        end
    endtask

    initial begin
        tick(); tick();
        check("R1 in reset", outs(), 4'b0000);
        rst = 0; tick();
        check("R1 after reset", outs(), 4'b0000);

        for (int n = 1; n <= 4; n++)
            for (int a = 0; a < n; a++) begin
                run_xfer(n, a);
                tick();
                check("R1 idle between runs", outs(), 4'b0000);
            end
        run_xfer(0, 0);

        for (int j = 1; j <= 8; j++) begin
            fifo_full = 1; tick();
            check("R8 raise", {3'b0, fifo_irq}, 4'b0001);
            for (int k = 1; k < j; k++) tick();
            fifo_rd = 1; tick(); fifo_rd = 0;
            if (j >= 5) check("R10 late clear", {3'b0, fifo_irq}, 4'b0000);
            else        check("R9 early ignored", {3'b0, fifo_irq}, 4'b0001);
            fifo_rd = 1;
            for (int k = 0; k < 6; k++) tick();
            fifo_rd = 0;
            check("R10 clear after window", {3'b0, fifo_irq}, 4'b0000);
            tick(); tick();
            check("R10 no re-raise while full", {3'b0, fifo_irq}, 4'b0000);
            fifo_full = 0; tick(); tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule